// File: doc/BRIEF.md
# Paged Serial Configuration Register Slave

This block is the configuration end of a four-wire serial bus. A host pulls the active-low select line down, clocks 24-bit words in on the data input, and each complete word is split into a 16-bit address (sent first) and an 8-bit data byte (sent last), both most significant bit first. Address bit 15 selects the direction. When that bit is 0 the word writes the data byte. When it is 1 the word reads, and the addressed byte is driven back on the data output during the last eight clocks of the same word.

A small physical register file is spread over several pages. One page register sits at a fixed address that decodes the same way whatever the current page is. The value written to it picks the bank that all following accesses to the mapped address window reach. The whole file is presented on a flat parallel bus for the surrounding logic. The block runs only on edges of the serial clock, so any clock rate and any duty cycle work. An asynchronous reset restores every register to its default.

Top module: `cfg_spi_slave`

## Requirements
- R1: While rst is high, and after it falls, the page register is 0, sdo is 0, and the register at flat index k (k = page*REGS + offset) holds (k*29 + 90) mod 256.
- R2: A write word is 24 bits, sampled on rising sclk edges while sel_n is low. Bits 23..8 are the address and bits 7..0 are the data, both MSB first. A mapped register changes only on the 24th rising edge of its word, and reg_bus[8k+7:8k] reflects register k.
- R3: Address 0x0000 (bit 15 clear) writes the page register. The mapped window is 0x0010..0x001F. Offset a-0x0010 in page p reaches flat index p*16 + (a-0x0010).
- R4: Several words may follow one another in a single low period of sel_n. The bit counter wraps after 24 bits, and each word is committed on its own.
- R5: Raising sel_n before a word is complete discards that word. No register changes, and the next word starts from bit 0.
- R6: On a read word (address bit 15 set), the register byte selected by address bits 14..0 is driven on sdo MSB first. sdo changes on falling sclk edges and is valid at rising edges 17 through 24 of the word. A read changes no register.
- R7: A write to an unmapped address, or to the window while the page register is 4 or more, has no effect. A read of such an address returns 0x00.
- R8: sdo is 0 while sel_n is high and during the 16 address bits of every word.
- R9: A read of address 0x8000 returns the current page register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset, active high, restores defaults |
| sel_n | input | 1 | Active-low select; high aborts the current word |
| sclk | input | 1 | Serial clock; input sampled on rising edges |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial read data, changes on falling edges |
| reg_bus | output | PAGES*REGS*8 | All physical registers, register k at bits 8k+7:8k |

## Verification
A bit counter that is off by one makes each word land shifted by one bit. The next committed write then puts a wrong byte on reg_bus, and a read presents a byte shifted by one position, so the error shows inside the same word. A wrong page value shows as soon as a write lands in another bank, or when the page register is read back. A lost abort corrupts the first word after sel_n falls again. The stimulus mixes random word groups with aborted words, so the bus is compared against the model after every word.

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave #(
  parameter int PAGES         = 4,
  parameter int REGS          = 16,
  parameter int BASE          = 16,
  parameter int PAGE_REG_ADDR = 0
) (
  input  logic                      rst,
  input  logic                      sel_n,
  input  logic                      sclk,
  input  logic                      sdi,
  output logic                      sdo,
  output logic [PAGES*REGS*8-1:0]   reg_bus
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NREG = PAGES * REGS;
  localparam int FW   = (NREG > 1) ? $clog2(NREG) : 1;

  logic [4:0]  cnt;
  logic [22:0] shreg;
  logic [7:0]  page;
  logic [7:0]  regs [NREG];
  logic [7:0]  obits;
  logic        sdo_en;
  logic [7:0]  rbyte;

  wire abort = rst | sel_n;

  function automatic logic mapped(input logic [14:0] a, input logic [7:0] pg);
    return (int'(pg) < PAGES) && (int'(a) >= BASE) && (int'(a) < BASE + REGS);
  endfunction

  function automatic logic [FW-1:0] flat(input logic [14:0] a, input logic [7:0] pg);
    return FW'(int'(pg) * REGS + int'(a) - BASE);
  endfunction

  always_ff @(posedge sclk or posedge abort) begin
    if (abort) begin
      cnt   <= '0;
      shreg <= '0;
    end else begin
      cnt   <= (cnt == 5'd23) ? 5'd0 : cnt + 5'd1;
      shreg <= {shreg[21:0], sdi};
    end
  end

  wire [15:0] waddr  = shreg[22:7];
  wire [7:0]  wdata  = {shreg[6:0], sdi};
  wire        commit = (cnt == 5'd23) && !waddr[15];

  always_ff @(posedge sclk or posedge rst) begin
    if (rst) begin
      page <= '0;
      for (int k = 0; k < NREG; k++) regs[k] <= 8'(k * 29 + 90);
    end else if (commit) begin
      if (waddr[14:0] == 15'(PAGE_REG_ADDR)) page <= wdata;
      else if (mapped(waddr[14:0], page)) regs[flat(waddr[14:0], page)] <= wdata;
    end
  end

  wire [15:0] raddr = shreg[15:0];

  always_comb begin
    if (raddr[14:0] == 15'(PAGE_REG_ADDR)) rbyte = page;
    else if (mapped(raddr[14:0], page))    rbyte = regs[flat(raddr[14:0], page)];
    else                                   rbyte = 8'h00;
  end

  always_ff @(negedge sclk or posedge abort) begin
    if (abort) begin
      obits  <= '0;
      sdo_en <= 1'b0;
    end else if (cnt == 5'd16) begin
      obits  <= rbyte;
      sdo_en <= raddr[15];
    end else if (cnt == 5'd0) begin
      sdo_en <= 1'b0;
    end else begin
      obits  <= {obits[6:0], 1'b0};
    end
  end

  assign sdo = sdo_en & obits[7];

  for (genvar k = 0; k < NREG; k++) begin : g_bus
    assign reg_bus[k*8 +: 8] = regs[k];
  end
endmodule

// File: rtl/cfg_spi_slave_chk.sv
module cfg_spi_slave_chk #(
  parameter int W = 8
) (
  input logic         rst,
  input logic         sel_n,
  input logic         sclk,
  input logic         sdo,
  input logic [4:0]   cnt,
  input logic [22:0]  shreg,
  input logic [7:0]   page,
  input logic [W-1:0] reg_bus
);
  timeunit 1ns; timeprecision 1ps;

  a_r2_bus_only_at_word_end: assert property (@(posedge sclk) disable iff (rst)
    (cnt != 5'd23) |=> $stable(reg_bus));

  a_r3_page_only_at_word_end: assert property (@(posedge sclk) disable iff (rst)
    (cnt != 5'd23) |=> $stable(page));

  a_r4_counter_wraps: assert property (@(posedge sclk) disable iff (rst || sel_n)
    (cnt == 5'd23) |=> (cnt == 5'd0));

  a_r6_read_keeps_regs: assert property (@(posedge sclk) disable iff (rst)
    (cnt == 5'd23 && shreg[22]) |=> ($stable(reg_bus) && $stable(page)));

  a_r8_quiet_address_phase: assert property (@(posedge sclk) disable iff (rst || sel_n)
    (cnt < 5'd16) |-> !sdo);
endmodule

bind cfg_spi_slave cfg_spi_slave_chk #(.W(PAGES*REGS*8)) chk_i (
  .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdo(sdo),
  .cnt(cnt), .shreg(shreg), .page(page), .reg_bus(reg_bus)
);

// File: tb/cfg_spi_slave_tb_top.sv
module cfg_spi_slave_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int PAGES = 4;
  localparam int REGS  = 16;
  localparam int NREG  = PAGES * REGS;

  logic clk = 1'b0;
  logic rst, sel_n, sclk, sdi;
  logic sdo;
  logic [NREG*8-1:0] reg_bus;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [NREG];
  int         pg;

  always #2.5 clk = ~clk;

  cfg_spi_slave #(.PAGES(PAGES), .REGS(REGS)) dut_i (
    .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .reg_bus(reg_bus)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_mapped(input logic [14:0] a, input int p);
    return (p < PAGES) && (a >= 15'h0010) && (a < 15'h0020);
  endfunction

  function automatic logic [7:0] exp_read(input logic [14:0] a);
    if (a == 15'h0000) return 8'(pg);
    if (is_mapped(a, pg)) return mem[pg * REGS + int'(a) - 16];
    return 8'h00;
  endfunction

  task automatic model_reset();
    pg = 0;
    for (int k = 0; k < NREG; k++) mem[k] = 8'(k * 29 + 90);
  endtask

  task automatic chk_bus(input string req);
    logic ok = 1'b1;
    int   bad = 0;
    for (int k = NREG - 1; k >= 0; k--)
      if (reg_bus[k*8 +: 8] !== mem[k]) begin ok = 1'b0; bad = k; end
    chk(ok, req, {bad, 24'h0, reg_bus[bad*8 +: 8]}, {bad, 24'h0, mem[bad]});
  endtask

  task automatic xfer(input logic [15:0] a, input logic [7:0] d, input int nbits,
                      output logic [7:0] got, output logic quiet);
    logic [23:0] w = {a, d};
    got = '0;
    quiet = 1'b1;
    for (int i = 23; i > 23 - nbits; i--) begin
      sdi = w[i];
      repeat ($urandom_range(1, 3)) @(negedge clk);
      if (i < 8) got[i] = sdo;
      else if (sdo !== 1'b0) quiet = 1'b0;
      sclk = 1'b1;
      repeat ($urandom_range(1, 4)) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel_on();
    sel_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo === 1'b0, "R8 sdo idle with select high", 64'(sdo), 64'h0);
  endtask

  task automatic word(input logic [15:0] a, input logic [7:0] d, input string req);
    logic [7:0] got, exp;
    logic       quiet;
    exp = exp_read(a[14:0]);
    xfer(a, d, 24, got, quiet);
    if (!a[15]) begin
      if (a[14:0] == 15'h0000) pg = int'(d);
      else if (is_mapped(a[14:0], pg)) mem[pg * REGS + int'(a[14:0]) - 16] = d;
    end else begin
      chk(got === exp, {req, " read data"}, 64'(got), 64'(exp));
    end
    chk(quiet, "R8 sdo quiet in address bits", 64'(quiet), 64'h1);
    repeat (2) @(negedge clk);
    chk_bus(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic       quiet;
    void'($urandom(32'd20417));
    rst = 1'b1; sel_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    chk_bus("R1 defaults during reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk_bus("R1 defaults after reset");
    chk(sdo === 1'b0, "R1 sdo after reset", 64'(sdo), 64'h0);

    sel_on(); word(16'h0013, 8'h3C, "R2 single write"); sel_off();
    sel_on(); word(16'h0000, 8'h02, "R3 page select"); sel_off();
    sel_on(); word(16'h001F, 8'hE1, "R3 write in page 2"); sel_off();
    sel_on(); word(16'h8000, 8'h00, "R9 page readback"); sel_off();
    sel_on(); word(16'h801F, 8'h55, "R6 read mapped"); sel_off();

    sel_on();
    word(16'h0010, 8'h11, "R4 first of group");
    word(16'h0000, 8'h01, "R4 page in group");
    word(16'h0011, 8'hA7, "R4 write in group");
    word(16'h8011, 8'h00, "R4 read in group");
    sel_off();

    sel_on();
    xfer(16'h0012, 8'hFF, 10, got, quiet);
    sel_off();
    chk_bus("R5 abort after 10 bits");
    sel_on();
    xfer(16'h0012, 8'hFF, 23, got, quiet);
    sel_off();
    chk_bus("R5 abort after 23 bits");
    sel_on(); word(16'h0012, 8'h6B, "R5 word after abort"); sel_off();

    sel_on();
    word(16'h0020, 8'h77, "R7 write above window");
    word(16'h000F, 8'h78, "R7 write below window");
    word(16'h8500, 8'h00, "R7 read unmapped");
    word(16'h0000, 8'h07, "R7 page out of range");
    word(16'h0010, 8'h99, "R7 write with bad page");
    word(16'h8010, 8'h00, "R7 read with bad page");
    word(16'h0000, 8'h03, "R3 page 3");
    word(16'h001A, 8'hC4, "R3 write in page 3");
    sel_off();

    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk_bus("R1 defaults after second reset");
    sel_on(); word(16'h8000, 8'h00, "R1 page zero after reset"); sel_off();

    for (int g = 0; g < 30; g++) begin
      sel_on();
      for (int f = 0, n = $urandom_range(1, 3); f < n; f++) begin
        int          c = $urandom_range(0, 9);
        logic [15:0] a;
        logic [7:0]  d = 8'($urandom);
        if (c < 2) begin a = 16'h0000; d = 8'($urandom_range(0, 5)); end
        else if (c < 7) a = 16'h0010 + 16'($urandom_range(0, 15));
        else a = {1'b0, 15'($urandom)};
        a[15] = ($urandom_range(0, 2) == 0);
        word(a, d, a[15] ? "R6 random read" : "R2 random write");
      end
      if ($urandom_range(0, 3) == 0) begin
        xfer(16'h0015, 8'h5A, $urandom_range(1, 23), got, quiet);
        sel_off();
        chk_bus("R5 random abort");
      end else begin
        sel_off();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule